// File: doc/BRIEF.md
# Dual-Width Timer/Counter with Compare Flags

This block is a general-purpose timer/counter. It runs either as an 8-bit counter with two separate compare registers, or as a 16-bit counter in which those two registers join into one 16-bit compare value. A clock-select field chooses what makes the counter advance. The choices are nothing, every system clock, one of four prescaled tick-enable inputs driven by an external divider, or a rising or falling edge on an external pin. The counter wraps to zero after it reaches its TOP value. TOP is either the largest count for the current width or the compare value.

Overflow and compare-match events set sticky flags. A mask register enables each flag onto one interrupt output. Software reaches every register through a plain single-cycle register port. Writes take effect at the next clock edge. Reads are combinational from the address. The port is a control interface, so it has no valid/ready handshake and no back-pressure.

Register addresses: 0 control, 1 count low byte, 2 count high byte, 3 compare A, 4 compare B, 5 flags, 6 mask. Any other address reads as zero.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: The control register holds the clock-select field in bits [2:0], the 16-bit-mode bit in bit 3, and the TOP-from-compare bit in bit 4. With clock-select 000, the counter holds its value.
- R3: With clock-select 001, the counter advances on every clock. In 8-bit mode only the low byte counts, and the high byte keeps whatever value it holds. When the count equals TOP on a tick, the next value is 0. TOP is 0xFF when bit 4 is 0, and compare A when bit 4 is 1.
- R4: Clock-select values 010, 011, 100 and 101 advance the counter on the clock edges where `pre_tick[0]`, `[1]`, `[2]` or `[3]` is high, respectively. The other `pre_tick` bits have no effect on the count.
- R5: Clock-select 111 counts each rising edge of `ext_pin`, and 110 counts each falling edge. The pin passes through a two-flop synchronizer and an edge detector first, so each edge gives exactly one count.
- R6: In 16-bit mode the counter is {high byte, low byte}. TOP is 0xFFFF, or {compare B, compare A} when bit 4 is 1.
- R7: Flag bit 0 (overflow) is set when a tick moves the counter from MAX to 0. MAX is 0xFF in 8-bit mode and 0xFFFF in 16-bit mode.
- R8: Flag bit 1 (match A) is set on a tick where the count equals the compare value. That value is compare A in 8-bit mode and {compare B, compare A} in 16-bit mode.
- R9: Flag bit 2 (match B) is set on a tick where the low byte equals compare B, in 8-bit mode only. In 16-bit mode it is never set.
- R10: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. An event in the same cycle wins over the clear.
- R11: `irq` is high while some flag bit and the mask bit in the same position (address 6) are both 1.
- R12: A write to either count byte loads that byte and overrides any tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pre_tick | input | 4 | Prescaled tick enables (/8, /64, /256, /1024) |
| ext_pin | input | 1 | External count pin (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the 16-bit wrap from 0xFFFF with the 16-bit compare near it. Counting there from zero would take tens of thousands of cycles. The bench instead stops the counter, preloads both count bytes and both compare bytes, and then runs a short burst. Compare B is set to 0xFF in that burst, so an ungated 8-bit B comparison would fire when the low byte passes 0xFF. The 8-bit TOP-from-compare path is swept over compare values from 0 to 255 in steps of 15, with two run lengths each.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_CNT_LO = 3'd1,
    RA_CNT_HI = 3'd2,
    RA_CMP_A  = 3'd3,
    RA_CMP_B  = 3'd4,
    RA_FLAG   = 3'd5,
    RA_MASK   = 3'd6
  } reg_addr_e;

  typedef enum logic [2:0] {
    CS_OFF   = 3'd0,
    CS_ALL   = 3'd1,
    CS_P8    = 3'd2,
    CS_P64   = 3'd3,
    CS_P256  = 3'd4,
    CS_P1024 = 3'd5,
    CS_FALL  = 3'd6,
    CS_RISE  = 3'd7
  } clk_sel_e;

  typedef struct packed {
    logic     top_cmp;
    logic     wide;
    clk_sel_e sel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FL_OVF = 0;
  localparam int unsigned FL_MA  = 1;
  localparam int unsigned FL_MB  = 2;
  localparam int unsigned PRE_N  = 4;

endpackage

// File: rtl/tick_select.sv
module tick_select
  import dual_timer_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_sel_e         sel,
  input  logic [PRE_N-1:0] pre_tick,
  input  logic             ext_pin,
  output logic             tick
);

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;
  logic              rise;
  logic              fall;
  logic [1:0]        pidx;

  assign pin_s = sync_q[SYNC_N-1];
  assign rise  = pin_s & ~prev_q;
  assign fall  = ~pin_s & prev_q;
  assign pidx  = 2'(3'(sel) - 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], ext_pin};
      prev_q <= pin_s;
    end
  end

  always_comb begin
    unique case (sel)
      CS_OFF:                            tick = 1'b0;
      CS_ALL:                            tick = 1'b1;
      CS_P8, CS_P64, CS_P256, CS_P1024:  tick = pre_tick[pidx];
      CS_FALL:                           tick = fall;
      CS_RISE:                           tick = rise;
      default:                           tick = 1'b0;
    endcase
  end

  // R5: two detected rising edges are never in back-to-back cycles
  a_r5_edge_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CS_RISE && tick) |=> (sel != CS_RISE || !tick));

endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            wide,
  input  logic            top_cmp,
  input  logic [BW-1:0]   cmp_a,
  input  logic [BW-1:0]   cmp_b,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wdata,
  output logic [2*BW-1:0] cnt,
  output logic            ovf_evt,
  output logic            match_a_evt,
  output logic            match_b_evt
);

  localparam int unsigned CW = 2 * BW;

  logic [CW-1:0] cnt_q, cur, max_v, cmp_v, top_v, step_v, cnt_d;
  logic          at_top;

  always_comb begin
    cur    = wide ? cnt_q : {{BW{1'b0}}, cnt_q[BW-1:0]};
    max_v  = wide ? {CW{1'b1}} : {{BW{1'b0}}, {BW{1'b1}}};
    cmp_v  = wide ? {cmp_b, cmp_a} : {{BW{1'b0}}, cmp_a};
    top_v  = top_cmp ? cmp_v : max_v;
    at_top = (cur == top_v);
    step_v = at_top ? '0 : cur + CW'(1);
    cnt_d  = cnt_q;
    if (tick) cnt_d = wide ? step_v : {cnt_q[CW-1:BW], step_v[BW-1:0]};
    if (wr_lo) cnt_d[BW-1:0]  = wdata;
    if (wr_hi) cnt_d[CW-1:BW] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt         = cnt_q;
  assign ovf_evt     = tick && (cur == max_v);
  assign match_a_evt = tick && (cur == cmp_v);
  assign match_b_evt = tick && !wide && (cnt_q[BW-1:0] == cmp_b);

  // R2: no tick and no write -> count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  // R3: a tick at TOP returns the low byte to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_top && !wr_lo && !wr_hi) |=> (cnt_q[BW-1:0] == '0));

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         wr_flag,
  input  logic         wr_mask,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);

  logic [N-1:0] flag_q, mask_q, clr;

  assign clr = wr_flag ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | set_evt;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign flags = flag_q;
  assign mask  = mask_q;
  assign irq   = |(flag_q & mask_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10: write-one clears a flag unless an event sets it in the same cycle
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && wdata[i] && !set_evt[i]) |=> !flag_q[i]);
  end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [PRE_N-1:0]  pre_tick,
  input  logic              ext_pin,
  output logic              irq
);

  localparam int unsigned CW = 2 * BYTE_W;

  reg_addr_e         addr_e;
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] cmp_a_q, cmp_b_q;
  logic [CW-1:0]     cnt;
  logic              tick;
  logic [FLAG_N-1:0] evt, flags, mask;
  logic              wr_flag;

  assign addr_e  = reg_addr_e'(reg_addr);
  assign wr_flag = reg_we && addr_e == RA_FLAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (reg_we) begin
      case (addr_e)
        RA_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RA_CMP_A: cmp_a_q <= reg_wdata;
        RA_CMP_B: cmp_b_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  tick_select #(.SYNC_N(SYNC_N)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (ctrl_q.sel),
    .pre_tick (pre_tick),
    .ext_pin  (ext_pin),
    .tick     (tick)
  );

  count_core #(.BW(BYTE_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .wide        (ctrl_q.wide),
    .top_cmp     (ctrl_q.top_cmp),
    .cmp_a       (cmp_a_q),
    .cmp_b       (cmp_b_q),
    .wr_lo       (reg_we && addr_e == RA_CNT_LO),
    .wr_hi       (reg_we && addr_e == RA_CNT_HI),
    .wdata       (reg_wdata),
    .cnt         (cnt),
    .ovf_evt     (evt[FL_OVF]),
    .match_a_evt (evt[FL_MA]),
    .match_b_evt (evt[FL_MB])
  );

  flag_bank #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (evt),
    .wr_flag (wr_flag),
    .wr_mask (reg_we && addr_e == RA_MASK),
    .wdata   (reg_wdata[FLAG_N-1:0]),
    .flags   (flags),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    case (addr_e)
      RA_CTRL:   reg_rdata = BYTE_W'(ctrl_q);
      RA_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
      RA_CNT_HI: reg_rdata = cnt[CW-1:BYTE_W];
      RA_CMP_A:  reg_rdata = cmp_a_q;
      RA_CMP_B:  reg_rdata = cmp_b_q;
      RA_FLAG:   reg_rdata = BYTE_W'(flags);
      RA_MASK:   reg_rdata = BYTE_W'(mask);
      default:   reg_rdata = '0;
    endcase
  end

  // R9: the B match flag never rises in 16-bit mode
  a_r9_no_b_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.wide && !wr_flag) |=> !$rose(flags[FL_MB]));

endmodule

// File: tb/test_dual_timer.sv
module test_dual_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [3:0] pre_tick = 4'd0;
  logic       ext_pin = 1'b0;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_timer i_dual_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pre_tick(pre_tick),
    .ext_pin(ext_pin), .irq(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic stop_clear();
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h07);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  // 8-bit run with TOP from compare A = t, compare B = 7, n ticks
  task automatic run8(input int t, input int n);
    logic [7:0] v;
    int ef;
    stop_clear();
    wr(3'd3, 8'(t));
    wr(3'd4, 8'd7);
    wr(3'd0, 8'h11);
    repeat (n) @(negedge clk);
    rd(3'd1, v);
    check($sformatf("R3 count t=%0d n=%0d", t, n), v, n % (t + 1));
    ef = ((t == 255 && n > 255) ? 1 : 0) | ((n > t) ? 2 : 0) | ((7 <= t && n > 7) ? 4 : 0);
    rd(3'd5, v);
    check($sformatf("R7/R8/R9 flags t=%0d n=%0d", t, n), v, ef);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      ext_pin = 1'b1; repeat (4) @(negedge clk);
      ext_pin = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reset reg %0d", a), v, 0);
    end
    check("R1 irq after reset", irq, 0);

    // R2 stopped counter holds
    wr(3'd1, 8'h33);
    repeat (10) @(negedge clk);
    rd(3'd1, v); check("R2 hold", v, 8'h33);

    // R3 sweep of TOP from compare A
    for (int t = 0; t < 256; t += 15) begin
      run8(t, t / 2 + 1);
      run8(t, 2 * (t + 1) + 3);
    end

    // R3 TOP = MAX in 8-bit, high byte untouched
    stop_clear();
    wr(3'd2, 8'h5A);
    wr(3'd3, 8'h40);
    wr(3'd4, 8'h07);
    wr(3'd0, 8'h01);
    repeat (300) @(negedge clk);
    rd(3'd1, v); check("R3 max wrap low", v, 300 % 256);
    rd(3'd2, v); check("R3 high byte kept", v, 8'h5A);
    rd(3'd5, v); check("R7 overflow 8-bit", v, 7);

    // R12 count write overrides tick
    wr(3'd1, 8'h20);
    rd(3'd1, v); check("R12 write wins", v, 8'h20);
    @(negedge clk);
    rd(3'd1, v); check("R12 count resumes", v, 8'h21);

    // R4 prescaled selects
    stop_clear();
    wr(3'd0, 8'h03);
    pre_tick = 4'b1101; repeat (5) @(negedge clk);
    rd(3'd1, v); check("R4 other enables ignored", v, 0);
    pre_tick = 4'b0010; repeat (4) @(negedge clk);
    pre_tick = 4'b0000;
    rd(3'd1, v); check("R4 select 011", v, 4);
    wr(3'd0, 8'h05);
    pre_tick = 4'b1000; repeat (3) @(negedge clk);
    pre_tick = 4'b0000;
    rd(3'd1, v); check("R4 select 101", v, 7);

    // R5 external edges
    stop_clear();
    wr(3'd0, 8'h07);
    pulses(3);
    rd(3'd1, v); check("R5 rising edges", v, 3);
    wr(3'd0, 8'h06);
    pulses(3);
    rd(3'd1, v); check("R5 falling edges", v, 6);

    // R6 16-bit wrap from 0xFFFF, compare {B,A}=0xFFF5
    stop_clear();
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hF5);
    wr(3'd4, 8'hFF);
    wr(3'd0, 8'h09);
    repeat (20) @(negedge clk);
    rd(3'd1, v); check("R6 wide low", v, 8'h04);
    rd(3'd2, v); check("R6 wide high", v, 8'h00);
    rd(3'd5, v); check("R7/R8/R9 wide flags", v, 3);

    // R6 16-bit TOP from {B,A} = 258
    stop_clear();
    wr(3'd3, 8'h02);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h19);
    repeat (600) @(negedge clk);
    rd(3'd1, v); check("R6 wide top low", v, 600 % 259);
    rd(3'd2, v); check("R6 wide top high", v, 0);
    rd(3'd5, v); check("R8 wide compare flags", v, 2);

    // R10 / R11 on a known flag set
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h01);
    repeat (300) @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd5, v); check("R10 setup flags", v, 7);
    wr(3'd5, 8'h00);
    rd(3'd5, v); check("R10 write zero keeps", v, 7);
    wr(3'd5, 8'h02);
    rd(3'd5, v); check("R10 clear bit1", v, 5);
    check("R11 irq masked off", irq, 0);
    wr(3'd6, 8'h02);
    check("R11 irq mask on cleared flag", irq, 0);
    wr(3'd6, 8'h04);
    check("R11 irq on", irq, 1);
    wr(3'd5, 8'h04);
    check("R11 irq after clear", irq, 0);
    rd(3'd6, v); check("R11 mask readback", v, 4);

    finish_run();
  end

endmodule